// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block is the main control unit of a single-cycle load/store datapath. It is purely combinational. It takes the 6-bit primary opcode of the instruction being executed and returns a 16-bit control word. That word steers the register-destination mux, the ALU operand mux, the write-back mux, the register-file write enable, the data-memory read and write strobes, the branch qualifier and a 2-bit ALU operation class. It also selects a dedicated upper-immediate write path and tells the immediate extender whether to sign-extend.

The decoder recognises six instruction classes:

- register-register ALU operations
- word load
- word store
- branch on equal
- add immediate
- load upper immediate

Every other opcode yields an all-zero word, so nothing is written and no memory is touched. Function-field decoding for register-register operations is not done here: the ALU operation class tells a downstream ALU control stage to do it.

A parameter selects how the decoder is built. One build is a 64-entry table computed at elaboration, one entry per opcode. The other is a minimised class decoder followed by a field generator. Both builds must produce identical words.

Top module: `mctl_main_decoder`

## Requirements
- R1: The control word depends on the opcode alone. Applying the same opcode again, after any sequence of other opcodes, yields the same word.
- R2: Word layout, from bit 0 upward:
  - bit 0: destination is the rd field
  - bit 1: ALU operand B is the immediate
  - bit 2: write-back from memory
  - bit 3: register write
  - bit 4: memory read
  - bit 5: memory write
  - bit 6: branch
  - bits 8:7: ALU class, where 00 = add, 01 = subtract, 10 = use function field
  - bit 9: upper-immediate write path
  - bit 10: sign-extend immediate
- R2 (continued): Opcode 000000 (register-register) gives 0x0109: bits 0 and 3 set, ALU class 10.
- R3: Opcode 100011 (load) gives 0x041E: operand immediate, write-back from memory, register write, memory read, sign extension, ALU class 00.
- R4: Opcode 101011 (store) gives 0x0422: operand immediate, memory write, sign extension, ALU class 00, no register write. Negative offsets work because bit 10 is set.
- R5: Opcode 000100 (branch equal) gives 0x04C0: branch, ALU class 01, sign extension, operand B from register.
- R6: Opcode 001000 (add immediate) gives 0x040A: register write, operand immediate, sign extension, ALU class 00, so the ALU adds without consulting the function field.
- R7: Opcode 001111 (load upper) gives 0x0208: register write and the upper-immediate path, no memory access, ALU class 00.
- R8: Every other opcode gives 0x0000.
- R9: The ALU class field is never 11, for any opcode.
- R10: Bits 15:11 are always zero.
- R11: Memory read and memory write are never both set, and a word that has memory write or branch set never has register write set.
- R12: The table build and the minimised build produce the same word for all 64 opcodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 6 | Primary opcode of the current instruction |
| ctrl_o | output | 16 | Control word, laid out as in R2 |

## Verification
Two functions share a single word, and so a single evaluation. For a load, the memory read strobe and the register write must appear together with write-back from memory. For load upper, the register write must appear together with the upper-immediate path while both memory strobes stay low. The bench sweeps all 64 opcodes through both builds and compares every word against values assembled from bit positions. The checker judges each settled word for these pairings and for the forbidden combinations.

// File: rtl/mctl_pkg.sv
package mctl_pkg;

    localparam int OP_W    = 6;
    localparam int CW_W    = 16;
    localparam int NUM_OPS = 1 << OP_W;
    localparam int RSVD_W  = CW_W - 11;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'b00,
        ALU_SUB   = 2'b01,
        ALU_FUNCT = 2'b10
    } alu_cls_e;

    typedef enum logic [OP_W-1:0] {
        OPC_REG   = 6'b000000,
        OPC_BEQ   = 6'b000100,
        OPC_ADDI  = 6'b001000,
        OPC_UPPER = 6'b001111,
        OPC_LOAD  = 6'b100011,
        OPC_STORE = 6'b101011
    } opcode_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_REG,
        K_LOAD,
        K_STORE,
        K_BRANCH,
        K_ADDIMM,
        K_UPPER
    } op_kind_e;

    // Packed MSB first: dst_rd lands on bit 0.
    typedef struct packed {
        logic [RSVD_W-1:0] rsvd;
        logic              imm_sext;
        logic              upper_sel;
        alu_cls_e          alu_cls;
        logic              branch;
        logic              mem_wr;
        logic              mem_rd;
        logic              reg_wr;
        logic              mem_to_reg;
        logic              alu_src_imm;
        logic              dst_rd;
    } ctrl_t;

    function automatic op_kind_e classify(input logic [OP_W-1:0] op);
        op_kind_e k;
        case (op)
            OPC_REG:   k = K_REG;
            OPC_LOAD:  k = K_LOAD;
            OPC_STORE: k = K_STORE;
            OPC_BEQ:   k = K_BRANCH;
            OPC_ADDI:  k = K_ADDIMM;
            OPC_UPPER: k = K_UPPER;
            default:   k = K_NONE;
        endcase
        return k;
    endfunction

    function automatic ctrl_t fields_for(input op_kind_e k);
        ctrl_t c;
        c = '0;
        c.alu_cls = ALU_ADD;
        case (k)
            K_REG: begin
                c.dst_rd  = 1'b1;
                c.reg_wr  = 1'b1;
                c.alu_cls = ALU_FUNCT;
            end
            K_LOAD: begin
                c.alu_src_imm = 1'b1;
                c.mem_to_reg  = 1'b1;
                c.reg_wr      = 1'b1;
                c.mem_rd      = 1'b1;
                c.imm_sext    = 1'b1;
            end
            K_STORE: begin
                c.alu_src_imm = 1'b1;
                c.mem_wr      = 1'b1;
                c.imm_sext    = 1'b1;
            end
            K_BRANCH: begin
                c.branch   = 1'b1;
                c.alu_cls  = ALU_SUB;
                c.imm_sext = 1'b1;
            end
            K_ADDIMM: begin
                c.alu_src_imm = 1'b1;
                c.reg_wr      = 1'b1;
                c.imm_sext    = 1'b1;
            end
            K_UPPER: begin
                c.reg_wr    = 1'b1;
                c.upper_sel = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mctl_classify.sv
module mctl_classify
    import mctl_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output op_kind_e        kind_o
);
    always_comb kind_o = classify(op_i);
endmodule

// File: rtl/mctl_fields.sv
module mctl_fields
    import mctl_pkg::*;
(
    input  op_kind_e         kind_i,
    output logic [CW_W-1:0]  word_o
);
    ctrl_t c;
    always_comb begin
        c      = fields_for(kind_i);
        word_o = c;
    end
endmodule

// File: rtl/mctl_rom.sv
module mctl_rom
    import mctl_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output logic [CW_W-1:0] word_o
);
    logic [CW_W-1:0] table_q [NUM_OPS];

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_entry
        assign table_q[i] = fields_for(classify(OP_W'(i)));
    end

    assign word_o = table_q[op_i];
endmodule

// File: rtl/mctl_main_decoder.sv
module mctl_main_decoder
    import mctl_pkg::*;
#(
    parameter bit USE_TABLE = 1'b0
) (
    input  logic [5:0]  op_i,
    output logic [15:0] ctrl_o
);
    if (USE_TABLE) begin : g_table
        mctl_rom u_rom (
            .op_i   (op_i),
            .word_o (ctrl_o)
        );
    end else begin : g_min
        op_kind_e kind;
        mctl_classify u_cls (
            .op_i   (op_i),
            .kind_o (kind)
        );
        mctl_fields u_fld (
            .kind_i (kind),
            .word_o (ctrl_o)
        );
    end
endmodule

// File: rtl/mctl_main_decoder_chk.sv
module mctl_main_decoder_chk
    import mctl_pkg::*;
(
    input logic [5:0]  op_i,
    input logic [15:0] ctrl_o
);
    ctrl_t c;
    assign c = ctrl_t'(ctrl_o);

    always_comb begin
        if (!$isunknown({op_i, ctrl_o})) begin
            a_r9_no_alu_cls3: assert (ctrl_o[8:7] != 2'b11);
            a_r10_reserved_zero: assert (ctrl_o[15:11] == '0);
            a_r11_rd_wr_excl: assert (!(c.mem_rd && c.mem_wr));
            a_r11_no_wb_on_store_branch:
                assert (!((c.mem_wr || c.branch) && c.reg_wr));
            a_r3_load_writes_back:
                assert (!c.mem_rd || (c.reg_wr && c.mem_to_reg));
            a_r7_upper_writes:
                assert (!c.upper_sel || (c.reg_wr && !c.mem_rd && !c.mem_wr));
            a_r4_mem_addr_signed:
                assert (!(c.mem_rd || c.mem_wr) || (c.imm_sext && c.alu_src_imm));
        end
    end
endmodule

bind mctl_main_decoder mctl_main_decoder_chk u_chk (
    .op_i   (op_i),
    .ctrl_o (ctrl_o)
);

// File: tb/mctl_main_decoder_tb.sv
module mctl_main_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  op;
    logic [15:0] word_min;
    logic [15:0] word_tab;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;

    always #10 clk = ~clk;

    mctl_main_decoder #(.USE_TABLE(1'b0)) u_dut (
        .op_i   (op),
        .ctrl_o (word_min)
    );
    mctl_main_decoder #(.USE_TABLE(1'b1)) u_dut_tab (
        .op_i   (op),
        .ctrl_o (word_tab)
    );

    function automatic logic [15:0] expect_word(input logic [5:0] o);
        logic [15:0] e;
        e = '0;
        case (o)
            6'b000000: e = (16'd1 << 0) | (16'd1 << 3) | (16'd2 << 7);
            6'b100011: e = (16'd1 << 1) | (16'd1 << 2) | (16'd1 << 3)
                         | (16'd1 << 4) | (16'd1 << 10);
            6'b101011: e = (16'd1 << 1) | (16'd1 << 5) | (16'd1 << 10);
            6'b000100: e = (16'd1 << 6) | (16'd1 << 7) | (16'd1 << 10);
            6'b001000: e = (16'd1 << 1) | (16'd1 << 3) | (16'd1 << 10);
            6'b001111: e = (16'd1 << 3) | (16'd1 << 9);
            default:   e = '0;
        endcase
        return e;
    endfunction

    function automatic string tag_for(input logic [5:0] o);
        case (o)
            6'b000000: return "R2";
            6'b100011: return "R3";
            6'b101011: return "R4";
            6'b000100: return "R5";
            6'b001000: return "R6";
            6'b001111: return "R7";
            default:   return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s op=%b actual=%h expected=%h", req, op, act, exp);
        end
    endtask

    task automatic apply(input logic [5:0] o);
        @(posedge clk);
        op = o;
        @(negedge clk);
    endtask

    initial begin
        op = 6'b000000;
        repeat (3) @(negedge clk);
        // reset state: register-register opcode held during reset (R2)
        check("R2", word_min, expect_word(6'b000000));
        @(posedge clk);
        rst = 1'b0;

        for (int i = 0; i < 64; i++) begin
            apply(6'(i));
            check(tag_for(6'(i)), word_min, expect_word(6'(i)));
            check("R12", word_tab, word_min);
            check("R9", {14'd0, word_min[8:7] == 2'b11}, 16'd0);
            check("R10", {11'd0, word_min[15:11]}, 16'd0);
            check("R11", {15'd0, (word_min[4] & word_min[5])
                          | ((word_min[5] | word_min[6]) & word_min[3])}, 16'd0);
        end

        // R1: revisit decoded opcodes in a different order
        for (int j = 63; j >= 0; j -= 7) begin
            apply(6'(j));
            check("R1", word_min, expect_word(6'(j)));
        end
        apply(6'b001111);
        check("R1", word_min, expect_word(6'b001111));
        apply(6'b100011);
        check("R1", word_min, expect_word(6'b100011));
        apply(6'b001111);
        check("R7", word_tab, 16'h0208);
        apply(6'b101011);
        check("R4", word_tab, 16'h0422);

        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule